// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus placed in front of a 512-byte storage array. The array is held in on-chip registers that a block RAM can absorb. SCL and SDA are brought into the system clock domain through synchronisers, and their edges are detected there. The block recognises start and stop conditions and decodes a device address byte. It then runs one of three sequences: a byte write, a random read (word address followed by a repeated start), or a current-address read.

The device address byte is laid out as follows, from MSB to LSB:
- a fixed type code `1010`;
- two bits compared with the `dev_pins` strap, bit 3 against `dev_pins[1]` and bit 2 against `dev_pins[0]`;
- the array-half select, which becomes address bit 8;
- the direction bit, where 1 means read and 0 means write.

A write is committed by the stop that follows a data byte. That stop also opens a self-timed busy window. During the window the bus side releases SDA and ignores all traffic. A host therefore learns that the write has finished when its address probe is acknowledged again. A protect input can lock the upper 256 bytes against writes.

Top module: `eep_i2c_slave`

## Requirements
- R1: During reset and on the clock after it, `sda_oe` is 0 (SDA released).
- R2: The slave pulls SDA low in the ninth clock of an address byte only when bits 7..4 are `1010` and bits 3..2 equal `dev_pins`. Otherwise it stays released until the next start or stop, and a stop after such a transaction opens no busy window.
- R3: A write transaction places the data byte at `{bit 1 of the address byte, word address}`. A later read of that location returns it, MSB first, with SDA low for a 0 bit.
- R4: Each byte sent by the slave advances the read pointer by one, and the pointer wraps from 511 to 0.
- R5: After the eighth data bit of a read byte the slave releases SDA. If the master leaves SDA high in the ninth clock, the slave sends nothing more until the next start.
- R6: The stop that follows a stored data byte starts a busy window of `TWR_CYCLES` system clocks. Within it the slave never drives SDA and does not acknowledge its own address. After it, the address is acknowledged again.
- R7: While `wp_i` is 1, a data byte aimed at addresses 256..511 is acknowledged but not stored, and its stop starts no busy window. Lower-half writes are still stored.
- R8: Bit 1 of the address byte selects the array half for both writes and reads.
- R9: A write-address transaction stopped before any data byte stores nothing and starts no busy window. It leaves the read pointer at the word address, and a current-address read with half bit 0 returns that byte.
- R10: A start condition in the middle of a transaction aborts it and begins decoding a fresh address byte.
- R11: When several data bytes follow one word address, each is acknowledged and only the last is stored, at that word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_pins | input | 2 | Address strap compared with address byte bits 3..2 |
| wp_i | input | 1 | 1 blocks writes to the upper half of the array |

## Verification
The bench builds the slave with `TWR_CYCLES` set to 400 and `dev_pins` set to `2'b10`. A 400-clock busy window outlasts one full probe (start, address byte and acknowledge, about 210 clocks). A probe sent straight after a write therefore lands inside the window, and a probe sent after waiting lands outside it. Both halves of the protect rule, the 511-to-0 wrap and the mismatching straps can then be exercised within a short run. Each SCL half period is 10 system clocks. This leaves room after every SCL edge for the three-register path from pad to `sda_oe`, so the expected drive can be compared on every clock.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_DATA,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } bus_state_t;
endpackage

// File: rtl/eep_bus_sampler.sv
module eep_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_d;
  logic sda_d;
  logic scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[STAGES-1];
      sda_d <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int DEPTH = 512,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) remain <= '0;
    else if (start) remain <= CW'(CYCLES);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  a_r6_runs_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  a_r6_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave #(
  parameter int MEM_BYTES   = 512,
  parameter int TWR_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] dev_pins,
  input  logic       wp_i
);
  import eep_pkg::*;

  localparam int AW = $clog2(MEM_BYTES);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy;
  logic [7:0] rd_data;

  bus_state_t state, ack_next;
  logic [3:0]    bitcnt;
  logic [7:0]    rx_sh, tx_sh;
  logic          sda_oe_q;
  logic          a8_q;
  logic [AW-1:0] ptr, waddr;
  logic [7:0]    pend_data;
  logic          pend_valid;
  logic          macked;
  logic          we_q;
  logic          dev_match;

  eep_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_array #(.DEPTH(MEM_BYTES), .DW(8)) u_array (
    .clk(clk), .we(we_q), .waddr(waddr), .wdata(pend_data),
    .raddr(ptr), .rdata(rd_data)
  );

  eep_write_timer #(.CYCLES(TWR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(we_q), .busy(busy)
  );

  assign dev_match = (rx_sh[7:4] == DEV_TYPE) && (rx_sh[3:2] == dev_pins);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ack_next   <= ST_IDLE;
      bitcnt     <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      sda_oe_q   <= 1'b0;
      a8_q       <= 1'b0;
      ptr        <= '0;
      waddr      <= '0;
      pend_data  <= '0;
      pend_valid <= 1'b0;
      macked     <= 1'b0;
      we_q       <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (busy) begin
        state      <= ST_IDLE;
        sda_oe_q   <= 1'b0;
        pend_valid <= 1'b0;
      end else if (start_det) begin
        state      <= ST_DEV;
        bitcnt     <= '0;
        sda_oe_q   <= 1'b0;
        pend_valid <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe_q <= 1'b0;
        if (pend_valid) begin
          we_q <= 1'b1;
          ptr  <= waddr + 1'b1;
        end
        pend_valid <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_WORD, ST_DATA: begin
            if (scl_rise && bitcnt != 4'd8) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (state == ST_DEV) begin
                if (dev_match) begin
                  sda_oe_q <= 1'b1;
                  state    <= ST_ACK;
                  a8_q     <= rx_sh[1];
                  if (rx_sh[0]) begin
                    ack_next <= ST_TX;
                    ptr      <= {rx_sh[1], ptr[AW-2:0]};
                  end else begin
                    ack_next <= ST_WORD;
                  end
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_WORD) begin
                waddr    <= {a8_q, rx_sh};
                ptr      <= {a8_q, rx_sh};
                sda_oe_q <= 1'b1;
                state    <= ST_ACK;
                ack_next <= ST_DATA;
              end else begin
                pend_data  <= rx_sh;
                pend_valid <= !(wp_i && waddr[AW-1]);
                sda_oe_q   <= 1'b1;
                state      <= ST_ACK;
                ack_next   <= ST_DATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (ack_next == ST_TX) begin
                tx_sh    <= rd_data;
                sda_oe_q <= ~rd_data[7];
                ptr      <= ptr + 1'b1;
                state    <= ST_TX;
              end else begin
                sda_oe_q <= 1'b0;
                state    <= ack_next;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                bitcnt   <= '0;
                sda_oe_q <= 1'b0;
                state    <= ST_MACK;
              end else begin
                bitcnt   <= bitcnt + 4'd1;
                tx_sh    <= {tx_sh[6:0], 1'b0};
                sda_oe_q <= ~tx_sh[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              macked <= ~sda_s;
            end else if (scl_fall) begin
              if (macked) begin
                tx_sh    <= rd_data;
                sda_oe_q <= ~rd_data[7];
                ptr      <= ptr + 1'b1;
                state    <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = sda_oe_q;

  // R1
  a_r1_released_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !sda_oe_q);
  // R2
  a_r2_quiet_in_address: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEV) |-> !sda_oe_q);
  // R5
  a_r5_release_for_master_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK) |-> !sda_oe_q);
  // R6
  a_r6_silent_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe_q);
  a_r6_cycle_follows_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(we_q));
endmodule

// File: tb/eep_i2c_slave_test.sv
module eep_i2c_slave_test;
  localparam int TWR = 400;
  localparam logic [1:0] PINS = 2'b10;

  logic clk = 1'b0;
  logic rst;
  logic scl;
  logic m_sda;
  logic wp;
  logic sda_oe;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit exp_valid = 0;
  logic exp_oe = 1'b0;
  string cur_req = "R1";
  logic [7:0] model_mem [512];

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  eep_i2c_slave #(.MEM_BYTES(512), .TWR_CYCLES(TWR), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .dev_pins(PINS), .wp_i(wp)
  );

  // per-clock comparison of the expected SDA drive
  always @(negedge clk) begin
    if (exp_valid && !finished) begin
      checks++;
      if (sda_oe !== exp_oe) begin
        errors++;
        $display("FAIL %s sda drive at %0t: actual=%0b expected=%0b",
                 cur_req, $time, sda_oe, exp_oe);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act,
                       input int expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_quiet(input int n);
    exp_oe = 1'b0;
    exp_valid = 1;
    wait_clk(n);
  endtask

  task automatic bus_start();
    exp_valid = 0;
    m_sda = 1'b1;
    wait_clk(10);
    scl = 1'b1;
    wait_clk(10);
    m_sda = 1'b0;
    wait_clk(10);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    exp_valid = 0;
    m_sda = 1'b0;
    wait_clk(10);
    scl = 1'b1;
    wait_clk(10);
    m_sda = 1'b1;
    wait_clk(10);
    exp_oe = 1'b0;
    exp_valid = 1;
  endtask

  task automatic clock_bit(input logic mbit, input logic exp_drive, output logic seen);
    exp_valid = 0;
    m_sda = mbit;
    wait_clk(5);
    exp_oe = exp_drive;
    exp_valid = 1;
    wait_clk(5);
    scl = 1'b1;
    wait_clk(5);
    seen = sda_line;
    wait_clk(5);
    exp_valid = 0;
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], 1'b0, s);
    clock_bit(1'b1, exp_ack, s);
    check((s == 1'b0) == exp_ack, req, int'(s == 1'b0), int'(exp_ack), "acknowledge");
  endtask

  task automatic recv_byte(input logic [7:0] expb, input bit master_ack, input string req);
    logic s;
    logic [7:0] got;
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, ~expb[i], s);
      got[i] = s;
    end
    clock_bit(~master_ack, 1'b0, s);
    check(got == expb, req, got, expb, "read byte");
  endtask

  function automatic logic [7:0] dev_byte(input logic a8, input logic rd);
    return {4'b1010, PINS, a8, rd};
  endfunction

  task automatic write_one(input logic [8:0] a, input logic [7:0] d, input string req);
    bus_start();
    send_byte(dev_byte(a[8], 1'b0), 1'b1, req);
    send_byte(a[7:0], 1'b1, req);
    send_byte(d, 1'b1, req);
    bus_stop();
    if (!(wp && a[8])) model_mem[a] = d;
  endtask

  task automatic probe(input bit exp_ack, input string req);
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), exp_ack, req);
    bus_stop();
  endtask

  task automatic rand_read(input logic [8:0] a, input int n, input string req);
    bus_start();
    send_byte(dev_byte(a[8], 1'b0), 1'b1, req);
    send_byte(a[7:0], 1'b1, req);
    bus_start();                       // repeated start (R10)
    send_byte(dev_byte(a[8], 1'b1), 1'b1, req);
    for (int k = 0; k < n; k++)
      recv_byte(model_mem[9'(a + 9'(k))], k < n - 1, req);
    wait_clk(3);
    check(sda_oe == 1'b0, "R5", sda_oe, 0, "released after master no-ack");
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic s;
    rst = 1'b1;
    scl = 1'b1;
    m_sda = 1'b1;
    wp = 1'b0;
    wait_clk(8);
    check(sda_oe == 1'b0, "R1", sda_oe, 0, "drive during reset");
    rst = 1'b0;
    wait_clk(2);
    check(sda_oe == 1'b0, "R1", sda_oe, 0, "drive after reset");
    idle_quiet(20);

    // R3 write then R6 busy polling
    cur_req = "R3";
    write_one(9'h005, 8'h3C, "R3");
    cur_req = "R6";
    probe(1'b0, "R6");
    idle_quiet(TWR + 40);
    probe(1'b1, "R6");

    cur_req = "R10";
    rand_read(9'h005, 1, "R3");

    // R8 upper half and R4 wrap
    cur_req = "R8";
    write_one(9'h1FF, 8'hA5, "R8");
    idle_quiet(TWR + 40);
    write_one(9'h000, 8'h11, "R8");
    idle_quiet(TWR + 40);
    write_one(9'h001, 8'h22, "R8");
    idle_quiet(TWR + 40);
    cur_req = "R4";
    rand_read(9'h1FF, 3, "R4");

    // R11 several data bytes, last one wins
    cur_req = "R11";
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), 1'b1, "R11");
    send_byte(8'h20, 1'b1, "R11");
    send_byte(8'h01, 1'b1, "R11");
    send_byte(8'h02, 1'b1, "R11");
    bus_stop();
    model_mem[9'h020] = 8'h02;
    idle_quiet(TWR + 40);
    rand_read(9'h020, 1, "R11");

    // R7 write protection of the upper half
    cur_req = "R7";
    write_one(9'h100, 8'h55, "R7");
    idle_quiet(TWR + 40);
    wp = 1'b1;
    write_one(9'h100, 8'h77, "R7");
    probe(1'b1, "R7");
    write_one(9'h010, 8'h66, "R7");
    idle_quiet(TWR + 40);
    wp = 1'b0;
    rand_read(9'h100, 1, "R7");
    rand_read(9'h010, 1, "R7");

    // R2 address mismatches
    cur_req = "R2";
    bus_start();
    send_byte({4'b1010, ~PINS, 1'b0, 1'b0}, 1'b0, "R2");
    send_byte(8'h30, 1'b0, "R2");
    send_byte(8'hEE, 1'b0, "R2");
    bus_stop();
    probe(1'b1, "R2");
    bus_start();
    send_byte({4'b0110, PINS, 1'b0, 1'b0}, 1'b0, "R2");
    bus_stop();
    probe(1'b1, "R2");

    // R9 word address only, then current-address read
    cur_req = "R9";
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), 1'b1, "R9");
    send_byte(8'h05, 1'b1, "R9");
    bus_stop();
    bus_start();
    send_byte(dev_byte(1'b0, 1'b1), 1'b1, "R9");
    recv_byte(model_mem[9'h005], 1'b0, "R9");
    bus_stop();

    // R10 abort mid-write with a start; nothing stored
    cur_req = "R10";
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), 1'b1, "R10");
    send_byte(8'h05, 1'b1, "R10");
    send_byte(8'h99, 1'b1, "R10");
    bus_start();
    send_byte(dev_byte(1'b0, 1'b1), 1'b1, "R10");
    recv_byte(model_mem[9'h005], 1'b0, "R10");
    bus_stop();
    probe(1'b1, "R10");

    idle_quiet(20);
    s = sda_oe;
    check(s == 1'b0, "R5", s, 0, "idle release at end");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule